// File: doc/BRIEF.md
# Transmit Frame Sequencer

This block sends one frame from a packet buffer in RAM to a baseband that takes 4-bit symbols, with no processor work during the send. Software gives a buffer start address, a backoff length and a one-cycle start pulse. The block counts out the backoff in symbol ticks, then switches the baseband into transmit mode and runs an 8-symbol clear-channel assessment. If the channel is reported busy, the attempt is dropped and a channel-busy pulse is raised. RAM is not touched in that case.

On a clear channel the block sends a fixed preamble and the start-of-frame delimiter. It then reads the buffer one byte at a time through a read port with one cycle of latency and sends each byte as two symbols. The frame check sequence is built from the bytes as they arrive and is sent as the last four symbols. The symbol stream uses a valid/ready handshake. Status is a busy level and a one-cycle done pulse.

Top module: `tx_frame_seq`

## Requirements
- R1: In idle, a start pulse captures `start_addr_i` and `backoff_i` and begins an attempt. A start pulse while `busy_o` is high has no effect on the frame being sent.
- R2: After the start, `bb_tx_mode_o` stays low for exactly `backoff_i`×20 symbol ticks. A value of 0 goes straight to the assessment.
- R3: The assessment holds `cca_active_o` high, with `bb_tx_mode_o` high, for exactly 8 symbol ticks. `cca_clear_i` is sampled on the 8th tick.
- R4: If `cca_clear_i` is low when sampled, the block pulses `chan_busy_o` for one cycle, returns to idle, issues no memory read and sends no symbol.
- R5: When the channel is clear, the stream opens with eight symbols of value 0x0, followed by the delimiter 0xA7 sent as 0x7 and then 0xA.
- R6: The first buffer byte, read at the start address, is the length L. L counts the two check bytes. The next L−2 bytes are read from consecutive addresses, so L−1 reads are made in total. If L<2, only the length byte is read.
- R7: Each buffer byte is sent as two symbols, bits [3:0] first and then bits [7:4].
- R8: The check value is a 16-bit CRC with polynomial x^16+x^12+x^5+1. It starts at 0, takes each byte bit 0 first, and covers the bytes after the length byte. It is sent low byte first, low nibble first, as the last four symbols.
- R9: While `sym_valid_o` is high and `sym_ready_i` is low, `sym_valid_o` stays high and `sym_data_o` does not change.
- R10: `busy_o` is high from the cycle after the start until the attempt ends. `done_o` pulses for one cycle after the last check symbol is accepted, and `busy_o` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| start_addr_i | input | AW | Buffer start address |
| backoff_i | input | BW | Backoff length in units of 20 symbols |
| sym_tick_i | input | 1 | One-cycle pulse per symbol period |
| bb_tx_mode_o | output | 1 | Baseband held in transmit mode |
| cca_active_o | output | 1 | Channel assessment in progress |
| cca_clear_i | input | 1 | Channel clear indication |
| mem_rd_en_o | output | 1 | Memory read request |
| mem_addr_o | output | AW | Memory read address |
| mem_rd_data_i | input | 8 | Read data, valid one cycle after the request |
| sym_valid_o | output | 1 | Symbol valid |
| sym_data_o | output | 4 | Symbol value |
| sym_ready_i | input | 1 | Symbol accepted by baseband |
| busy_o | output | 1 | Attempt in progress |
| done_o | output | 1 | Frame fully sent (one-cycle pulse) |
| chan_busy_o | output | 1 | Attempt aborted on a busy channel (one-cycle pulse) |

## Verification
The bench counts symbol ticks in the backoff and assessment windows, including a zero backoff. A timer that is off by one unit, or that loads late, shows up as the wrong tick count. It sends frames with lengths 1 and 2 and an irregular ready pattern. A wrong length subtraction gives an extra or missing read and a misplaced check value, and a handshake slip drops or repeats a symbol. The bench also sends a busy channel, where a design that reads RAM early or leaks preamble symbols is caught. A second start pulse during backoff would redirect the buffer address in a design that does not guard the start.

// File: rtl/tx_seq_pkg.sv
package tx_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BACKOFF,
    ST_CCA,
    ST_HDR,
    ST_RD,
    ST_LAT,
    ST_BYTE,
    ST_FCS
  } tx_state_t;

  localparam logic [7:0]  SFD_VALUE     = 8'hA7;
  localparam int          PREAMBLE_SYMS = 8;
  localparam int          CCA_SYMS      = 8;
  localparam int          BACKOFF_UNIT  = 20;
  localparam logic [15:0] CRC_POLY_REFL = 16'h8408;

  // Reflected CRC-16 update, bit 0 of the byte first.
  function automatic logic [15:0] crc16_byte(input logic [15:0] c_in, input logic [7:0] d);
    logic [15:0] c;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ d[i]) c = (c >> 1) ^ CRC_POLY_REFL;
      else             c = c >> 1;
    end
    return c;
  endfunction

  // Payload bytes after the length byte: L-2, clamped at zero.
  function automatic logic [7:0] payload_count(input logic [7:0] len);
    return (len >= 8'd2) ? (len - 8'd2) : 8'd0;
  endfunction

endpackage

// File: rtl/tx_sym_timer.sv
module tx_sym_timer #(
  parameter int TW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  input  logic          tick_i,
  output logic          expire_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           cnt_q <= '0;
    else if (load_i)                      cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = tick_i && (cnt_q == TW'(1));
endmodule

// File: rtl/tx_fcs_crc.sv
module tx_fcs_crc
  import tx_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear_i,
  input  logic        en_i,
  input  logic [7:0]  data_i,
  output logic [15:0] crc_o
);
  logic [15:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       crc_q <= '0;
    else if (clear_i) crc_q <= '0;
    else if (en_i)    crc_q <= crc16_byte(crc_q, data_i);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/tx_frame_seq.sv
module tx_frame_seq
  import tx_seq_pkg::*;
#(
  parameter int AW = 8,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [BW-1:0] backoff_i,
  input  logic          sym_tick_i,
  output logic          bb_tx_mode_o,
  output logic          cca_active_o,
  input  logic          cca_clear_i,
  output logic          mem_rd_en_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [7:0]    mem_rd_data_i,
  output logic          sym_valid_o,
  output logic [3:0]    sym_data_o,
  input  logic          sym_ready_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          chan_busy_o
);
  localparam int TW      = BW + 5;
  localparam int HDR_SYMS = PREAMBLE_SYMS + 2;
  localparam int HCW     = $clog2(HDR_SYMS);

  tx_state_t      state_q;
  logic [AW-1:0]  addr_q;
  logic [7:0]     remain_q;
  logic [7:0]     byte_q;
  logic           nib_hi_q;
  logic           is_len_q;
  logic [HCW-1:0] hdr_cnt_q;
  logic [1:0]     fcs_cnt_q;
  logic           done_q, cbusy_q;

  // Named internal events.
  logic           sym_fire, tmr_load, tmr_expire, crc_en, crc_clear, start_ok;
  logic [TW-1:0]  tmr_val;
  logic [15:0]    crc_val;

  assign start_ok  = (state_q == ST_IDLE) && start_i;
  assign sym_fire  = sym_valid_o && sym_ready_i;
  assign crc_en    = (state_q == ST_LAT) && !is_len_q;
  assign crc_clear = start_ok;
  assign tmr_load  = (start_ok) || ((state_q == ST_BACKOFF) && tmr_expire);
  assign tmr_val   = (start_ok && backoff_i != '0) ? TW'(backoff_i) * TW'(BACKOFF_UNIT)
                                                   : TW'(CCA_SYMS);

  tx_sym_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .load_val_i(tmr_val),
    .tick_i(sym_tick_i), .expire_o(tmr_expire)
  );

  tx_fcs_crc u_crc (
    .clk(clk), .rst_n(rst_n), .clear_i(crc_clear), .en_i(crc_en),
    .data_i(mem_rd_data_i), .crc_o(crc_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      remain_q  <= '0;
      byte_q    <= '0;
      nib_hi_q  <= 1'b0;
      is_len_q  <= 1'b0;
      hdr_cnt_q <= '0;
      fcs_cnt_q <= '0;
      done_q    <= 1'b0;
      cbusy_q   <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      cbusy_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          addr_q  <= start_addr_i;
          state_q <= (backoff_i != '0) ? ST_BACKOFF : ST_CCA;
        end
        ST_BACKOFF: if (tmr_expire) state_q <= ST_CCA;
        ST_CCA: if (tmr_expire) begin
          if (cca_clear_i) begin
            state_q   <= ST_HDR;
            hdr_cnt_q <= '0;
          end else begin
            state_q <= ST_IDLE;
            cbusy_q <= 1'b1;
          end
        end
        ST_HDR: if (sym_fire) begin
          if (hdr_cnt_q == HCW'(HDR_SYMS - 1)) begin
            state_q  <= ST_RD;
            is_len_q <= 1'b1;
          end else begin
            hdr_cnt_q <= hdr_cnt_q + 1'b1;
          end
        end
        ST_RD: state_q <= ST_LAT;
        ST_LAT: begin
          byte_q   <= mem_rd_data_i;
          addr_q   <= addr_q + 1'b1;
          nib_hi_q <= 1'b0;
          is_len_q <= 1'b0;
          remain_q <= is_len_q ? payload_count(mem_rd_data_i) : remain_q - 1'b1;
          state_q  <= ST_BYTE;
        end
        ST_BYTE: if (sym_fire) begin
          if (!nib_hi_q) begin
            nib_hi_q <= 1'b1;
          end else if (remain_q == '0) begin
            state_q   <= ST_FCS;
            fcs_cnt_q <= '0;
          end else begin
            state_q <= ST_RD;
          end
        end
        ST_FCS: if (sym_fire) begin
          if (fcs_cnt_q == 2'd3) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            fcs_cnt_q <= fcs_cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    sym_valid_o = 1'b0;
    sym_data_o  = 4'h0;
    unique case (state_q)
      ST_HDR: begin
        sym_valid_o = 1'b1;
        if (hdr_cnt_q == HCW'(PREAMBLE_SYMS))          sym_data_o = SFD_VALUE[3:0];
        else if (hdr_cnt_q == HCW'(PREAMBLE_SYMS + 1)) sym_data_o = SFD_VALUE[7:4];
        else                                           sym_data_o = 4'h0;
      end
      ST_BYTE: begin
        sym_valid_o = 1'b1;
        sym_data_o  = nib_hi_q ? byte_q[7:4] : byte_q[3:0];
      end
      ST_FCS: begin
        sym_valid_o = 1'b1;
        sym_data_o  = crc_val[{fcs_cnt_q, 2'b00} +: 4];
      end
      default: ;
    endcase
  end

  assign mem_rd_en_o  = (state_q == ST_RD);
  assign mem_addr_o   = addr_q;
  assign bb_tx_mode_o = (state_q != ST_IDLE) && (state_q != ST_BACKOFF);
  assign cca_active_o = (state_q == ST_CCA);
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign chan_busy_o  = cbusy_q;
endmodule

// File: rtl/tx_frame_seq_chk.sv
module tx_frame_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy_o,
  input logic       sym_valid_o,
  input logic [3:0] sym_data_o,
  input logic       sym_ready_i,
  input logic       bb_tx_mode_o,
  input logic       cca_active_o,
  input logic       mem_rd_en_o,
  input logic       done_o,
  input logic       chan_busy_o,
  input logic       crc_en
);
  assert_sym_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid_o && !sym_ready_i |=> sym_valid_o && $stable(sym_data_o));

  assert_sym_in_tx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid_o |-> bb_tx_mode_o && !cca_active_o);

  assert_read_after_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en_o |-> bb_tx_mode_o && !cca_active_o);

  assert_single_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en_o |=> !mem_rd_en_o);

  assert_busy_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chan_busy_o |-> $past(cca_active_o) && !busy_o);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && !chan_busy_o);

  assert_cca_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cca_active_o |-> bb_tx_mode_o);

  assert_crc_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    crc_en |-> !sym_valid_o);
endmodule

bind tx_frame_seq tx_frame_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .sym_valid_o(sym_valid_o),
  .sym_data_o(sym_data_o), .sym_ready_i(sym_ready_i), .bb_tx_mode_o(bb_tx_mode_o),
  .cca_active_o(cca_active_o), .mem_rd_en_o(mem_rd_en_o), .done_o(done_o),
  .chan_busy_o(chan_busy_o), .crc_en(crc_en)
);

// File: tb/test_tx_frame_seq.sv
module test_tx_frame_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int BW = 4;
  localparam int TICK_DIV = 4;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0;
  logic [BW-1:0] backoff_i = '0;
  logic sym_tick_i = 1'b0, cca_clear_i = 1'b1, sym_ready_i = 1'b0;
  logic bb_tx_mode_o, cca_active_o, mem_rd_en_o, sym_valid_o, busy_o, done_o, chan_busy_o;
  logic [AW-1:0] mem_addr_o;
  logic [7:0] mem_rd_data_i = '0;
  logic [3:0] sym_data_o;

  tx_frame_seq #(.AW(AW), .BW(BW)) i_tx_frame_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .backoff_i(backoff_i), .sym_tick_i(sym_tick_i), .bb_tx_mode_o(bb_tx_mode_o),
    .cca_active_o(cca_active_o), .cca_clear_i(cca_clear_i), .mem_rd_en_o(mem_rd_en_o),
    .mem_addr_o(mem_addr_o), .mem_rd_data_i(mem_rd_data_i), .sym_valid_o(sym_valid_o),
    .sym_data_o(sym_data_o), .sym_ready_i(sym_ready_i), .busy_o(busy_o),
    .done_o(done_o), .chan_busy_o(chan_busy_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] mem [256];
  always @(posedge clk) if (mem_rd_en_o) mem_rd_data_i <= mem[mem_addr_o];

  int errors = 0, checks = 0;
  int cyc = 0, rd_cnt = 0, done_cnt = 0, cbusy_cnt = 0, bo_ticks = 0, cca_ticks = 0;
  int stall_viol = 0, ready_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic stall_pend = 1'b0;
  logic [3:0] stall_data = '0;
  logic [3:0] rx_q[$];
  logic [3:0] exp_q[$];
  int exp_reads = 0;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Drives tick and ready, then observes, all away from the active edge.
  always @(negedge clk) begin
    logic rdy;
    cyc++;
    sym_tick_i = (cyc % TICK_DIV) == 0;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rdy = (ready_mode == 0) ? 1'b1 : lfsr[0];
    sym_ready_i = rdy;
    if (stall_pend && (!sym_valid_o || sym_data_o != stall_data)) stall_viol++;
    stall_pend = sym_valid_o && !rdy;
    stall_data = sym_data_o;
    if (sym_valid_o && rdy) rx_q.push_back(sym_data_o);
    if (mem_rd_en_o) rd_cnt++;
    if (done_o) done_cnt++;
    if (chan_busy_o) cbusy_cnt++;
    if (busy_o && !bb_tx_mode_o && sym_tick_i) bo_ticks++;
    if (cca_active_o && sym_tick_i) cca_ticks++;
    if (cyc > WATCHDOG) begin
      errors++; checks++;
      $display("FAIL watchdog: got cycle %0d expected below %0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // CRC restated as the non-reflected form on reversed bits.
  function automatic logic [15:0] ref_crc(input logic [15:0] r_in, input logic [7:0] d);
    logic [15:0] r; logic fb;
    r = r_in;
    for (int i = 0; i < 8; i++) begin
      fb = r[15] ^ d[i];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  function automatic logic [15:0] rev16(input logic [15:0] v);
    logic [15:0] o;
    for (int i = 0; i < 16; i++) o[i] = v[15-i];
    return o;
  endfunction

  task automatic build_expected(input int addr);
    int len, npay; logic [15:0] r, c; logic [7:0] b;
    exp_q.delete();
    for (int i = 0; i < 8; i++) exp_q.push_back(4'h0);
    exp_q.push_back(4'h7); exp_q.push_back(4'hA);
    len = mem[addr[7:0]];
    npay = (len >= 2) ? len - 2 : 0;
    exp_q.push_back(len[3:0]); exp_q.push_back(len[7:4]);
    r = '0;
    for (int i = 1; i <= npay; i++) begin
      b = mem[(addr + i) % 256];
      exp_q.push_back(b[3:0]); exp_q.push_back(b[7:4]);
      r = ref_crc(r, b);
    end
    c = rev16(r);
    exp_q.push_back(c[3:0]); exp_q.push_back(c[7:4]);
    exp_q.push_back(c[11:8]); exp_q.push_back(c[15:12]);
    exp_reads = 1 + npay;
  endtask

  task automatic run_attempt(input int addr, input int units, input int mode, input bit clear,
                             input bit second_start);
    rx_q.delete();
    rd_cnt = 0; done_cnt = 0; cbusy_cnt = 0; bo_ticks = 0; cca_ticks = 0; stall_viol = 0;
    ready_mode = mode;
    cca_clear_i = clear;
    @(negedge clk);
    start_i = 1'b1; start_addr_i = addr[AW-1:0]; backoff_i = units[BW-1:0];
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R10 busy after start", busy_o, 1);
    if (second_start) begin
      repeat (3) @(negedge clk);
      start_i = 1'b1; start_addr_i = 8'hC0; backoff_i = 4'd1;
      @(negedge clk);
      start_i = 1'b0;
    end
    for (int i = 0; i < 20000 && busy_o; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_stream(input string req);
    int bad = 0;
    check(rx_q.size() == exp_q.size(), {req, " symbol count"}, rx_q.size(), exp_q.size());
    if (rx_q.size() == exp_q.size())
      for (int i = 0; i < rx_q.size(); i++) if (rx_q[i] != exp_q[i]) bad++;
    check(bad == 0, {req, " symbol mismatches"}, bad, 0);
  endtask

  task automatic check_crc_tail(input string req);
    int n = rx_q.size(), m = exp_q.size();
    int got, exp;
    if (n < 4 || m < 4) begin check(1'b0, req, n, m); return; end
    got = {rx_q[n-1], rx_q[n-2], rx_q[n-3], rx_q[n-4]};
    exp = {exp_q[m-1], exp_q[m-2], exp_q[m-3], exp_q[m-4]};
    check(got == exp, req, got, exp);
  endtask

  task automatic test_reset();
    check(busy_o == 0 && sym_valid_o == 0, "R10 reset idle", {busy_o, sym_valid_o}, 0);
    check(bb_tx_mode_o == 0 && mem_rd_en_o == 0, "R1 reset outputs quiet",
          {bb_tx_mode_o, mem_rd_en_o}, 0);
  endtask

  task automatic test_basic();
    mem[8'h10] = 8'd6; mem[8'h11] = 8'h41; mem[8'h12] = 8'h88;
    mem[8'h13] = 8'h03; mem[8'h14] = 8'hF5;
    build_expected(8'h10);
    run_attempt(8'h10, 1, 0, 1'b1, 1'b0);
    check(bo_ticks == 20, "R2 backoff ticks units=1", bo_ticks, 20);
    check(cca_ticks == 8, "R3 assessment ticks", cca_ticks, 8);
    check(rd_cnt == exp_reads, "R6 read count L=6", rd_cnt, exp_reads);
    check_stream("R5 R7 basic frame");
    check_crc_tail("R8 check value basic");
    check(done_cnt == 1 && cbusy_cnt == 0, "R10 done pulse", done_cnt, 1);
  endtask

  task automatic test_stall();
    mem[8'h30] = 8'd9;
    for (int i = 1; i < 8; i++) mem[8'h30 + i] = 8'(i * 37 + 5);
    build_expected(8'h30);
    run_attempt(8'h30, 0, 1, 1'b1, 1'b0);
    check(bo_ticks == 0, "R2 zero backoff", bo_ticks, 0);
    check(stall_viol == 0, "R9 held under stall", stall_viol, 0);
    check_stream("R7 stalled frame");
    check_crc_tail("R8 check value stalled");
  endtask

  task automatic test_busy_chan();
    mem[8'h50] = 8'd5;
    run_attempt(8'h50, 2, 0, 1'b0, 1'b0);
    check(bo_ticks == 40, "R2 backoff ticks units=2", bo_ticks, 40);
    check(cbusy_cnt == 1, "R4 channel busy pulse", cbusy_cnt, 1);
    check(rd_cnt == 0, "R4 no reads on busy", rd_cnt, 0);
    check(rx_q.size() == 0, "R4 no symbols on busy", rx_q.size(), 0);
    check(done_cnt == 0 && busy_o == 0, "R4 back to idle", done_cnt, 0);
  endtask

  task automatic test_short_len();
    mem[8'h70] = 8'd1;
    build_expected(8'h70);
    run_attempt(8'h70, 0, 0, 1'b1, 1'b0);
    check(rd_cnt == 1, "R6 L=1 single read", rd_cnt, 1);
    check_stream("R6 L=1 frame");
    mem[8'h78] = 8'd2;
    build_expected(8'h78);
    run_attempt(8'h78, 0, 1, 1'b1, 1'b0);
    check(rd_cnt == 1, "R6 L=2 single read", rd_cnt, 1);
    check_crc_tail("R8 empty payload check value");
  endtask

  task automatic test_restart_ignored();
    mem[8'h90] = 8'd4; mem[8'h91] = 8'h5A; mem[8'h92] = 8'hC3;
    mem[8'hC0] = 8'd7;
    build_expected(8'h90);
    run_attempt(8'h90, 1, 0, 1'b1, 1'b1);
    check(rd_cnt == exp_reads, "R1 reads of first buffer", rd_cnt, exp_reads);
    check_stream("R1 start while busy ignored");
    check(bo_ticks == 20, "R1 backoff not reloaded", bo_ticks, 20);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i ^ 8'h5C);
    repeat (4) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    test_basic();
    test_stall();
    test_busy_chan();
    test_short_len();
    test_restart_ignored();
    finish_run();
  end
endmodule